// File: doc/BRIEF.md
# Multi-function DIO pin router

This block shares four bidirectional digital pins among three internal functions and a plain general-purpose path. The three functions are an outgoing data-ready indicator, an outgoing alarm indicator and an incoming sync clock that paces sensor sampling. A 16-bit function register turns each function on or off, sets its polarity or active edge, and picks the pin it uses. A second 16-bit register holds the direction and level of every pin that no enabled function has claimed.

Software reaches both registers through a one-bit address, a write strobe and a read strobe. Read data comes back one cycle after the read strobe, flagged by a valid bit. Pin levels coming in from the pads pass through a two-flop synchronizer before anything reads them or looks for edges on them. Per-pin output enables and output values leave the block from registers. When the sync function is enabled, edges on its pin replace the internal sample-clock request on the sample tick output.

Top module: `pin_func_router`

## Requirements
- R1: After reset the function register reads 0x000D and the GPIO register reads 0x0000 while all pins are low. Pin 2 (index 1) is then an output enable carrying the data-ready level with active-high polarity, and all other pins are inputs.
- R2: Address 0 selects the function register and address 1 the GPIO register. A write strobe stores the write data. A read strobe returns data with the read-valid flag one cycle later. Function bits [15:12] and GPIO bits [15:8] always read back as zero.
- R3: With function bit 3 set, the pin selected by bits [1:0] (00 = pin 1, 01 = pin 2, 10 = pin 3, 11 = pin 4) is an output one cycle later. It carries data-ready unchanged when bit 2 is 1 and inverted when bit 2 is 0.
- R4: With function bit 11 set, the pin selected by bits [9:8] is an output carrying the alarm level. The level is unchanged when bit 10 is 1 and inverted when bit 10 is 0.
- R5: With function bit 7 set, the pin selected by bits [5:4] is forced to input. The sample tick pulses for one cycle on a rising edge of that synchronized pin when bit 6 is 1, or on a falling edge when bit 6 is 0. The pulse appears in the cycle after the second synchronizer flop takes the new level. The internal tick request has no effect in this mode.
- R6: With function bit 7 clear, the sample tick follows the internal tick request in the same cycle.
- R7: When several enabled functions select the same pin, the sync input takes it first, then data-ready, then alarm. A function that loses is not driven on that pin.
- R8: A pin that no enabled function selects takes its output enable from GPIO bit [p] (1 = output) and its driven value from GPIO bit [4+p], one cycle after the register changes.
- R9: In a GPIO read, bit [4+p] returns the synchronized live level when pin p is an unclaimed input, and the stored level otherwise. The pinLevel output always shows the synchronized levels.
- R10: A function whose enable bit is clear claims no pin, so its former pin falls back to the GPIO settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrite | input | 1 | Register write strobe |
| regRead | input | 1 | Register read strobe |
| regAddr | input | 1 | Register select: 0 function, 1 GPIO |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data, valid with regRdValid |
| regRdValid | output | 1 | Read data valid, one cycle after regRead |
| pinIn | input | 4 | Pad input levels, asynchronous |
| pinOe | output | 4 | Per-pin output enable |
| pinOut | output | 4 | Per-pin driven value |
| pinLevel | output | 4 | Synchronized pad levels |
| dataReadyIn | input | 1 | Internal data-ready level, active high |
| alarmIn | input | 1 | Internal alarm level, active high |
| intTick | input | 1 | Internal sample-clock request |
| sampleTick | output | 1 | Sample request to the sampling logic |

## Verification
Some rules are checked on every cycle, and for every pin, by the assertions. A pin claimed by the sync input stays undriven. A pin claimed by data-ready or alarm drives the previous cycle's level with the configured polarity. An unclaimed pin follows the GPIO bits. A register write lands as written, and read-valid follows the read strobe. Other behaviour needs directed scenarios and comes only from the bench. These are the three-way priority when functions share a pin, the edge sense and exact cycle of the sample tick after the synchronizer, the masking of the internal tick, and the mix of live and stored levels in a GPIO read.

// File: rtl/pin_router_pkg.sv
package pin_router_pkg;

  // Register geometry and field placement (placement is decoded by software)
  localparam int unsigned REG_W    = 16;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned FIELD_W  = SEL_W + 2;
  localparam int unsigned DRDY_LSB = 0;
  localparam int unsigned SYNC_LSB = DRDY_LSB + FIELD_W;
  localparam int unsigned ALRM_LSB = SYNC_LSB + FIELD_W;
  localparam int unsigned FUNC_USED_W = ALRM_LSB + FIELD_W;

  localparam logic [REG_W-1:0] FUNC_RESET = 16'h000D;
  localparam logic [REG_W-1:0] FUNC_MASK  = REG_W'((1 << FUNC_USED_W) - 1);

  typedef enum logic [0:0] {
    ADDR_FUNC = 1'b0,
    ADDR_GPIO = 1'b1
  } regAddrE;

  // One function field: enable, polarity/edge, pin select (MSB to LSB)
  typedef struct packed {
    logic             en;
    logic             pol;
    logic [SEL_W-1:0] sel;
  } funcFieldT;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic rdAny;
    logic rdFunc;
  } rdStrobeT;

endpackage

// File: rtl/pin_router_ctrl.sv
module pin_router_ctrl
  import pin_router_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrite,
  input  logic                regRead,
  input  logic                regAddr,
  input  logic [REG_W-1:0]    regWdata,
  output rdStrobeT            rdStb,
  output funcFieldT           syncCfg,
  output logic                drPol,
  output logic                alPol,
  output logic [NUM_PINS-1:0] gpioDir,
  output logic [NUM_PINS-1:0] gpioLvl,
  output logic [NUM_PINS-1:0] syncClaim,
  output logic [NUM_PINS-1:0] drClaim,
  output logic [NUM_PINS-1:0] alClaim,
  output logic [REG_W-1:0]    funcView
);

  localparam int unsigned GPIO_W = 2 * NUM_PINS;

  logic [REG_W-1:0]  funcReg;
  logic [GPIO_W-1:0] gpioReg;
  logic              wrFunc;
  logic              wrGpio;
  funcFieldT         drCfg;
  funcFieldT         alCfg;

  assign wrFunc = regWrite && (regAddrE'(regAddr) == ADDR_FUNC);
  assign wrGpio = regWrite && (regAddrE'(regAddr) == ADDR_GPIO);

  assign rdStb.rdAny  = regRead;
  assign rdStb.rdFunc = regRead && (regAddrE'(regAddr) == ADDR_FUNC);

  // Configuration registers; unused bits are held at zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      funcReg <= FUNC_RESET;
      gpioReg <= '0;
    end else begin
      if (wrFunc) funcReg <= regWdata & FUNC_MASK;
      if (wrGpio) gpioReg <= regWdata[GPIO_W-1:0];
    end
  end

  assign funcView = funcReg;
  assign drCfg    = funcFieldT'(funcReg[DRDY_LSB +: FIELD_W]);
  assign syncCfg  = funcFieldT'(funcReg[SYNC_LSB +: FIELD_W]);
  assign alCfg    = funcFieldT'(funcReg[ALRM_LSB +: FIELD_W]);
  assign drPol    = drCfg.pol;
  assign alPol    = alCfg.pol;
  assign gpioDir  = gpioReg[NUM_PINS-1:0];
  assign gpioLvl  = gpioReg[GPIO_W-1:NUM_PINS];

  // Fixed-priority claim resolution: sync, then data-ready, then alarm
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_claim
    assign syncClaim[p] = syncCfg.en && (syncCfg.sel == SEL_W'(p));
    assign drClaim[p]   = drCfg.en && (drCfg.sel == SEL_W'(p)) && !syncClaim[p];
    assign alClaim[p]   = alCfg.en && (alCfg.sel == SEL_W'(p))
                          && !syncClaim[p] && !drClaim[p];
  end

  // R2: a function write lands masked
  assert_func_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrFunc |=> (funcView == ($past(regWdata) & FUNC_MASK)));

  // R8: a GPIO write lands in direction and level
  assert_gpio_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrGpio |=> ({gpioLvl, gpioDir} == $past(regWdata[GPIO_W-1:0])));

endmodule

// File: rtl/pin_router_dpath.sv
module pin_router_dpath
  import pin_router_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  rdStrobeT            rdStb,
  input  funcFieldT           syncCfg,
  input  logic                drPol,
  input  logic                alPol,
  input  logic [NUM_PINS-1:0] gpioDir,
  input  logic [NUM_PINS-1:0] gpioLvl,
  input  logic [NUM_PINS-1:0] syncClaim,
  input  logic [NUM_PINS-1:0] drClaim,
  input  logic [NUM_PINS-1:0] alClaim,
  input  logic [REG_W-1:0]    funcView,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                dataReadyIn,
  input  logic                alarmIn,
  input  logic                intTick,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinLevel,
  output logic                sampleTick,
  output logic [REG_W-1:0]    regRdata,
  output logic                regRdValid
);

  localparam int unsigned GPIO_W = 2 * NUM_PINS;

  logic [NUM_PINS-1:0] syncStage [SYNC_STAGES];
  logic [NUM_PINS-1:0] prevLevel;
  logic [NUM_PINS-1:0] oeNext;
  logic [NUM_PINS-1:0] outNext;
  logic [NUM_PINS-1:0] claimAny;
  logic [NUM_PINS-1:0] lvlView;
  logic [REG_W-1:0]    gpioView;
  logic                drVal;
  logic                alVal;
  logic                selNow;
  logic                selPrev;
  logic                edgeHit;

  // Input synchronizer chain plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncStage[s] <= '0;
      prevLevel <= '0;
    end else begin
      syncStage[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncStage[s] <= syncStage[s-1];
      prevLevel <= syncStage[SYNC_STAGES-1];
    end
  end

  assign pinLevel = syncStage[SYNC_STAGES-1];

  // Sync-clock edge selection
  assign selNow     = pinLevel[syncCfg.sel];
  assign selPrev    = prevLevel[syncCfg.sel];
  assign edgeHit    = syncCfg.pol ? (selNow && !selPrev) : (!selNow && selPrev);
  assign sampleTick = syncCfg.en ? edgeHit : intTick;

  // Outgoing indicator levels after polarity
  assign drVal = drPol ? dataReadyIn : !dataReadyIn;
  assign alVal = alPol ? alarmIn : !alarmIn;

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      claimAny[p] = syncClaim[p] || drClaim[p] || alClaim[p];
      if (syncClaim[p]) begin
        oeNext[p]  = 1'b0;
        outNext[p] = 1'b0;
      end else if (drClaim[p]) begin
        oeNext[p]  = 1'b1;
        outNext[p] = drVal;
      end else if (alClaim[p]) begin
        oeNext[p]  = 1'b1;
        outNext[p] = alVal;
      end else begin
        oeNext[p]  = gpioDir[p];
        outNext[p] = gpioLvl[p];
      end
      lvlView[p] = (claimAny[p] || gpioDir[p]) ? gpioLvl[p] : pinLevel[p];
    end
  end

  always_comb begin
    gpioView = '0;
    gpioView[GPIO_W-1:0] = {lvlView, gpioDir};
  end

  // Registered pin drivers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinOe  <= '0;
      pinOut <= '0;
    end else begin
      pinOe  <= oeNext;
      pinOut <= outNext;
    end
  end

  // Registered read port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdata   <= '0;
      regRdValid <= 1'b0;
    end else begin
      regRdValid <= rdStb.rdAny;
      if (rdStb.rdAny) regRdata <= rdStb.rdFunc ? funcView : gpioView;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    // R5: a sync-claimed pin is never driven
    assert_sync_input_R5: assert property (@(posedge clk) disable iff (!rstN)
      syncClaim[p] |=> !pinOe[p]);
    // R3: data-ready pin drives the polarity-adjusted level
    assert_drdy_drive_R3: assert property (@(posedge clk) disable iff (!rstN)
      drClaim[p] |=> (pinOe[p] && (pinOut[p] == $past(dataReadyIn ~^ drPol))));
    // R4: alarm pin drives the polarity-adjusted level
    assert_alarm_drive_R4: assert property (@(posedge clk) disable iff (!rstN)
      alClaim[p] |=> (pinOe[p] && (pinOut[p] == $past(alarmIn ~^ alPol))));
    // R8: an unclaimed pin follows the GPIO register
    assert_gpio_fallback_R8: assert property (@(posedge clk) disable iff (!rstN)
      !(syncClaim[p] || drClaim[p] || alClaim[p]) |=>
        ((pinOe[p] == $past(gpioDir[p])) && (pinOut[p] == $past(gpioLvl[p]))));
  end

  // R2: read-valid follows the read strobe by one cycle
  assert_read_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdStb.rdAny |=> regRdValid);
  assert_read_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb.rdAny |=> !regRdValid);

endmodule

// File: rtl/pin_func_router.sv
module pin_func_router
  import pin_router_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrite,
  input  logic                regRead,
  input  logic                regAddr,
  input  logic [REG_W-1:0]    regWdata,
  output logic [REG_W-1:0]    regRdata,
  output logic                regRdValid,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinLevel,
  input  logic                dataReadyIn,
  input  logic                alarmIn,
  input  logic                intTick,
  output logic                sampleTick
);

  rdStrobeT            rdStb;
  funcFieldT           syncCfg;
  logic                drPol;
  logic                alPol;
  logic [NUM_PINS-1:0] gpioDir;
  logic [NUM_PINS-1:0] gpioLvl;
  logic [NUM_PINS-1:0] syncClaim;
  logic [NUM_PINS-1:0] drClaim;
  logic [NUM_PINS-1:0] alClaim;
  logic [REG_W-1:0]    funcView;

  pin_router_ctrl #(
    .NUM_PINS (NUM_PINS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrite  (regWrite),
    .regRead   (regRead),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .rdStb     (rdStb),
    .syncCfg   (syncCfg),
    .drPol     (drPol),
    .alPol     (alPol),
    .gpioDir   (gpioDir),
    .gpioLvl   (gpioLvl),
    .syncClaim (syncClaim),
    .drClaim   (drClaim),
    .alClaim   (alClaim),
    .funcView  (funcView)
  );

  pin_router_dpath #(
    .NUM_PINS    (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .rdStb       (rdStb),
    .syncCfg     (syncCfg),
    .drPol       (drPol),
    .alPol       (alPol),
    .gpioDir     (gpioDir),
    .gpioLvl     (gpioLvl),
    .syncClaim   (syncClaim),
    .drClaim     (drClaim),
    .alClaim     (alClaim),
    .funcView    (funcView),
    .pinIn       (pinIn),
    .dataReadyIn (dataReadyIn),
    .alarmIn     (alarmIn),
    .intTick     (intTick),
    .pinOe       (pinOe),
    .pinOut      (pinOut),
    .pinLevel    (pinLevel),
    .sampleTick  (sampleTick),
    .regRdata    (regRdata),
    .regRdValid  (regRdValid)
  );

endmodule

// File: tb/pin_func_router_tb.sv
module pin_func_router_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NPINS      = 4;

  typedef enum int {K_OE, K_OUT, K_TICK, K_RD, K_LVL} kindE;
  typedef struct {
    kindE        kind;
    logic [15:0] exp;
    string       tag;
  } itemT;

  itemT sbQ[$];
  event sampleEv;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  logic             clk = 1'b0;
  logic             rstN;
  logic             regWrite, regRead, regAddr;
  logic [15:0]      regWdata;
  logic [15:0]      regRdata;
  logic             regRdValid;
  logic [NPINS-1:0] pinIn, pinOe, pinOut, pinLevel;
  logic             dataReadyIn, alarmIn, intTick, sampleTick;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_func_router u_dut (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regRead(regRead),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .regRdValid(regRdValid), .pinIn(pinIn), .pinOe(pinOe), .pinOut(pinOut),
    .pinLevel(pinLevel), .dataReadyIn(dataReadyIn), .alarmIn(alarmIn),
    .intTick(intTick), .sampleTick(sampleTick)
  );

  // Monitor: pops expected items and compares against the ports
  task automatic drainQ();
    while (sbQ.size() > 0) begin
      itemT        it;
      logic [15:0] act;
      bit          bad;
      it  = sbQ.pop_front();
      bad = 1'b0;
      case (it.kind)
        K_OE:    act = {12'b0, pinOe};
        K_OUT:   act = {12'b0, pinOut};
        K_TICK:  act = {15'b0, sampleTick};
        K_LVL:   act = {12'b0, pinLevel};
        default: begin act = regRdata; bad = !regRdValid; end
      endcase
      checks++;
      if (bad || (act !== it.exp)) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h (valid=%b)", it.tag, act, it.exp, regRdValid);
      end
    end
  endtask

  initial begin
    forever begin
      @(sampleEv);
      drainQ();
    end
  end

  // Driver side
  task automatic expectItem(kindE k, logic [15:0] v, string tag);
    itemT it;
    it.kind = k; it.exp = v; it.tag = tag;
    sbQ.push_back(it);
    -> sampleEv;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeReg(logic a, logic [15:0] d);
    regAddr = a; regWdata = d; regWrite = 1'b1;
    tick();
    regWrite = 1'b0;
  endtask

  task automatic readExpect(logic a, logic [15:0] e, string tag);
    regAddr = a; regRead = 1'b1;
    tick();
    regRead = 1'b0;
    expectItem(K_RD, e, tag);
  endtask

  task automatic expectPins(logic [3:0] oe, logic [3:0] out, string tag);
    expectItem(K_OE, {12'b0, oe}, tag);
    expectItem(K_OUT, {12'b0, out}, tag);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; regWrite = 1'b0; regRead = 1'b0; regAddr = 1'b0;
    regWdata = '0; pinIn = '0; dataReadyIn = 1'b0; alarmIn = 1'b0; intTick = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();

    // R1: reset state
    expectPins(4'b0010, 4'b0000, "R1 reset pins");
    readExpect(1'b0, 16'h000D, "R1 function reset");
    readExpect(1'b1, 16'h0000, "R1 gpio reset");
    dataReadyIn = 1'b1;
    tick();
    expectItem(K_OUT, 16'h0002, "R1 default data-ready on pin 2");

    // R3: data-ready on pin 1, inverted
    writeReg(1'b0, 16'h0008);
    tick();
    expectPins(4'b0001, 4'b0000, "R3 inverted drdy high");
    dataReadyIn = 1'b0;
    tick();
    expectPins(4'b0001, 4'b0001, "R3 inverted drdy low");

    // R4: alarm on pin 3, both polarities
    alarmIn = 1'b1;
    writeReg(1'b0, 16'h0E00);
    tick();
    expectPins(4'b0100, 4'b0100, "R4 alarm active high");
    writeReg(1'b0, 16'h0A00);
    tick();
    expectPins(4'b0100, 4'b0000, "R4 alarm active low");

    // R10: all disabled -> GPIO inputs
    writeReg(1'b0, 16'h0000);
    tick();
    expectItem(K_OE, 16'h0000, "R10 disabled functions release pins");

    // R8 / R2: GPIO outputs, upper bits ignored
    writeReg(1'b1, 16'hFF15);
    tick();
    expectPins(4'b0101, 4'b0001, "R8 gpio drive");
    readExpect(1'b1, 16'h0015, "R2 gpio readback upper zero");

    // R9: live levels on input pins
    pinIn = 4'b1010;
    repeat (3) tick();
    readExpect(1'b1, 16'h00B5, "R9 gpio live/stored mix");
    expectItem(K_LVL, 16'h000A, "R9 pinLevel");

    // R2: unused function bits
    writeReg(1'b0, 16'hF000);
    readExpect(1'b0, 16'h0000, "R2 function unused bits");

    // R5: sync on pin 1, rising edge
    writeReg(1'b0, 16'h00C0);
    tick();
    expectItem(K_OE, 16'h0004, "R5 sync pin forced input");
    intTick = 1'b1;
    #1;
    expectItem(K_TICK, 16'h0000, "R5 internal tick masked");
    @(negedge clk);
    intTick = 1'b0;
    pinIn = 4'b1011;
    tick(); tick();
    expectItem(K_TICK, 16'h0001, "R5 rising edge tick");
    tick();
    expectItem(K_TICK, 16'h0000, "R5 tick one cycle");
    writeReg(1'b0, 16'h0080);
    pinIn = 4'b1010;
    tick(); tick();
    expectItem(K_TICK, 16'h0001, "R5 falling edge tick");
    tick();
    pinIn = 4'b1011;
    tick(); tick();
    expectItem(K_TICK, 16'h0000, "R5 rising ignored in falling mode");

    // R6: internal tick passes when sync disabled
    writeReg(1'b0, 16'h0000);
    intTick = 1'b1;
    #1;
    expectItem(K_TICK, 16'h0001, "R6 internal tick passes");
    @(negedge clk);
    intTick = 1'b0;
    #1;
    expectItem(K_TICK, 16'h0000, "R6 internal tick low");
    @(negedge clk);

    // R7: priority on shared pin 2
    dataReadyIn = 1'b0;
    alarmIn = 1'b1;
    writeReg(1'b0, 16'h0DDD);
    tick();
    expectPins(4'b0101, 4'b0001, "R7 sync wins");
    writeReg(1'b0, 16'h0D5D);
    tick();
    expectPins(4'b0111, 4'b0001, "R7 drdy over alarm");
    writeReg(1'b0, 16'h0D55);
    tick();
    expectPins(4'b0111, 4'b0011, "R7 alarm alone");

    tick();
    drainQ();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule